// File: doc/BRIEF.md
# Line-Counted Coast Window Generator

This block produces a coast level for a line-locked clock loop further down the video path. While coast is high, the loop should hold its phase and ignore horizontal sync, because the equalisation pulses that surround the vertical sync interval would otherwise corrupt its line timing. The window always covers the vertical sync interval. It can extend a programmable number of lines before vertical sync and a programmable number of lines after it.

Both extensions are counted in horizontal sync periods. The block takes single-cycle strobes for each horizontal sync edge and for the leading and trailing edges of vertical sync. It counts lines between consecutive vertical leading edges and keeps that total as the frame length. It then uses that length to predict where the next vertical sync will fall, so that coast can open early. Once the trailing edge has arrived, a down-counter holds coast for the requested number of extra lines.

Top module: `coast_window`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, coast is 0.
- R2: A vertical leading strobe makes coast 1 in the next cycle. Coast stays 1 until at least the vertical trailing strobe.
- R3: With both extension values at 0, coast rises only on the vertical leading strobe. It is 0 in the cycle after the vertical trailing strobe.
- R4: The frame length is the number of horizontal strobes from one vertical leading strobe up to the next. A horizontal strobe in the same cycle as a vertical leading strobe counts as line 1 of the new frame.
- R5: After a frame length L has been measured, with a pre-coast value P from 1 to L-1, coast rises in the cycle after the horizontal strobe that brings the line count to L-P.
- R6: When P is equal to or larger than the measured frame length, coast stays 1 for the whole frame.
- R7: After the vertical trailing strobe, with a post-coast value Q greater than 0, coast stays 1 until the Q-th horizontal strobe that follows the trailing strobe. It falls in the cycle after that strobe. A horizontal strobe in the same cycle as the trailing strobe is not counted.
- R8: Until two vertical leading strobes have been seen since reset, the pre-coast value has no effect on coast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hsTick | input | 1 | One-cycle strobe per horizontal sync edge |
| vsLead | input | 1 | One-cycle strobe at the vertical sync leading edge |
| vsTrail | input | 1 | One-cycle strobe at the vertical sync trailing edge |
| preLines | input | 8 | Lines by which coast opens ahead of vertical sync |
| postLines | input | 8 | Lines by which coast stays open after vertical sync |
| coast | output | 1 | Coast level, high while horizontal sync is to be ignored |

## Verification
There are two cases where the line counter and the vertical edge logic act in the same cycle. In the first, a horizontal strobe arrives together with the vertical leading strobe: that strobe must restart the count at 1, not be lost. The bench sends them together. It then measures where coast rises in the frame that follows, because a dropped line shifts the predicted opening by one line. In the second, a horizontal strobe lands on the trailing strobe. The post-coast counter must load and must not also decrement, so the bench checks that coast stays high for exactly the full post-coast count of strobes after that cycle.

// File: rtl/coast_pkg.sv
package coast_pkg;
  // strobes from the control to the line datapath
  typedef struct packed {
    logic clrLine;    // restart the line count at a new frame
    logic incLine;    // one horizontal sync period has passed
    logic latchLen;   // store the finished frame's length
    logic predictEn;  // a frame length is known, early opening allowed
  } lineCtl_t;
endpackage

// File: rtl/coast_dp.sv
module coast_dp
  import coast_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int PRE_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  lineCtl_t         ctl,
  input  logic [PRE_W-1:0] preLines,
  output logic             preHit
);
  localparam int SUM_W = ((LINE_W > PRE_W) ? LINE_W : PRE_W) + 1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] lineCnt;
  logic [LINE_W-1:0] frameLen;
  logic [SUM_W-1:0]  reach;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt  <= '0;
      frameLen <= '0;
    end else if (ctl.clrLine) begin
      if (ctl.latchLen) frameLen <= lineCnt;
      lineCnt <= ctl.incLine ? LINE_W'(1) : '0;
    end else if (ctl.incLine && lineCnt != LINE_MAX) begin
      lineCnt <= lineCnt + LINE_W'(1);
    end
  end

  // count + pre >= length avoids underflow when pre exceeds the length
  always_comb begin
    reach  = SUM_W'(lineCnt) + SUM_W'(preLines);
    preHit = ctl.predictEn && (preLines != '0) && (reach >= SUM_W'(frameLen));
  end
endmodule

// File: rtl/coast_ctrl.sv
module coast_ctrl
  import coast_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsTick,
  input  logic             vsLead,
  input  logic             vsTrail,
  input  logic [PRE_W-1:0] postLines,
  input  logic             preHit,
  output lineCtl_t         ctl,
  output logic             coast
);
  logic             inVs;
  logic             seenLead;
  logic             lenValid;
  logic [PRE_W-1:0] postLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inVs     <= 1'b0;
      seenLead <= 1'b0;
      lenValid <= 1'b0;
    end else if (vsLead) begin
      inVs     <= 1'b1;
      seenLead <= 1'b1;
      if (seenLead) lenValid <= 1'b1;
    end else if (vsTrail) begin
      inVs <= 1'b0;
    end
  end

  // the trailing strobe loads; a coincident line strobe is not counted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            postLeft <= '0;
    else if (vsTrail)                     postLeft <= postLines;
    else if (hsTick && postLeft != '0)    postLeft <= postLeft - PRE_W'(1);
  end

  always_comb begin
    ctl.clrLine   = vsLead;
    ctl.incLine   = hsTick;
    ctl.latchLen  = vsLead && seenLead;
    ctl.predictEn = lenValid;
    coast         = inVs || (postLeft != '0) || preHit;
  end
endmodule

// File: rtl/coast_window.sv
module coast_window
  import coast_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int PRE_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsTick,
  input  logic             vsLead,
  input  logic             vsTrail,
  input  logic [PRE_W-1:0] preLines,
  input  logic [PRE_W-1:0] postLines,
  output logic             coast
);
  lineCtl_t ctl;
  logic     preHit;

  coast_ctrl #(.PRE_W(PRE_W)) ctrl (
    .clk(clk), .rstN(rstN), .hsTick(hsTick), .vsLead(vsLead),
    .vsTrail(vsTrail), .postLines(postLines), .preHit(preHit),
    .ctl(ctl), .coast(coast)
  );

  coast_dp #(.LINE_W(LINE_W), .PRE_W(PRE_W)) dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .preLines(preLines), .preHit(preHit)
  );
endmodule

// File: rtl/coast_window_chk.sv
module coast_window_chk #(
  parameter int PRE_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             hsTick,
  input logic             vsLead,
  input logic             vsTrail,
  input logic [PRE_W-1:0] preLines,
  input logic [PRE_W-1:0] postLines,
  input logic             coast
);
  logic seenEdge = 1'b0;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  // R1: quiet while held in reset
  always @(negedge clk)
    if (seenEdge && !rstN) a_r1_reset_quiet: assert (!coast);

  // R2: leading strobe opens the window next cycle
  a_r2_lead_opens: assert property (@(posedge clk) disable iff (!rstN)
    vsLead |=> coast);

  // R3: with no extensions the trailing strobe closes the window
  a_r3_default_close: assert property (@(posedge clk) disable iff (!rstN)
    (vsTrail && !vsLead && postLines == '0 && preLines == '0) |=> (!coast || preLines != '0));

  // R5: without a line or leading strobe only a new pre value can open it
  a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    (!coast && !hsTick && !vsLead && !vsTrail) |=> (!coast || preLines != $past(preLines)));

  // R7: without a line or trailing strobe only a new pre value can close it
  a_r7_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    (coast && !hsTick && !vsTrail) |=> (coast || preLines != $past(preLines)));
endmodule

bind coast_window coast_window_chk #(.PRE_W(PRE_W)) chk (
  .clk(clk), .rstN(rstN), .hsTick(hsTick), .vsLead(vsLead), .vsTrail(vsTrail),
  .preLines(preLines), .postLines(postLines), .coast(coast)
);

// File: tb/coast_window_test.sv
module coast_window_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic       hsTick, vsLead, vsTrail;
  logic [7:0] preLines, postLines;
  logic       coast;

  always #10 clk = ~clk;

  coast_window uut (
    .clk(clk), .rstN(rstN), .hsTick(hsTick), .vsLead(vsLead), .vsTrail(vsTrail),
    .preLines(preLines), .postLines(postLines), .coast(coast)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int leads  = 0;
  int prevL  = 0;
  int curCnt = 0;

  // scenario table: frame lines, vsync lines, pre, post, frame count
  localparam int ROWS = 6;
  localparam int tL[ROWS]    = '{12, 12, 12,  9, 9, 14};
  localparam int tW[ROWS]    = '{ 3,  3,  3,  2, 2,  2};
  localparam int tPre[ROWS]  = '{ 4,  0,  3, 20, 9,  1};
  localparam int tPost[ROWS] = '{ 0,  0,  2,  1, 4,  0};
  localparam int tN[ROWS]    = '{ 1,  1,  2,  2, 1,  1};

  task automatic check(bit act, bit expV, string tag, string what);
    checks++;
    if (act !== expV) begin
      fails++;
      $display("FAIL %s %s: coast=%0b expected %0b", tag, what, act, expV);
    end
  endtask

  task automatic cyc(bit h, bit l, bit t);
    @(negedge clk);
    hsTick = h; vsLead = l; vsTrail = t;
    @(negedge clk);
    hsTick = 0; vsLead = 0; vsTrail = 0;
  endtask

  function automatic bit predHit(int i, int pre);
    return (leads >= 2) && (pre != 0) && (i + pre >= prevL);
  endfunction

  function automatic string tagFor(int i, int vsW, int pre);
    if (predHit(i, pre)) return (pre >= prevL) ? "R6" : "R5";
    if (leads < 2 && pre > 0) return "R8";
    return (i <= vsW) ? "R3" : "R7";
  endfunction

  task automatic runFrame(int L, int vsW, int pre, int post, bit coLead, string force_tag);
    bit expV;
    preLines = 8'(pre); postLines = 8'(post);
    cyc(coLead, 1, 0);
    if (leads >= 1) prevL = curCnt;
    leads++;
    curCnt = coLead ? 1 : 0;
    check(coast, 1'b1, "R2", "after vsync lead");
    for (int i = (coLead ? 2 : 1); i <= L; i++) begin
      cyc(1, 0, 0);
      curCnt++;
      expV = (i <= vsW + ((post > 0) ? post : 1) - 1) || predHit(i, pre);
      check(coast, expV, (force_tag != "") ? force_tag : tagFor(i, vsW, pre),
            $sformatf("line %0d", i));
      if (i == vsW) begin
        cyc(0, 0, 1);
        check(coast, (post > 0) || predHit(i, pre), "R7", "after vsync trail");
      end
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 0; hsTick = 0; vsLead = 0; vsTrail = 0; preLines = 0; postLines = 0;
    repeat (3) @(negedge clk);
    check(coast, 1'b0, "R1", "during reset");
    rstN = 1;
    @(negedge clk);
    check(coast, 1'b0, "R1", "after reset release");

    // table walk
    for (int r = 0; r < ROWS; r++)
      for (int f = 0; f < tN[r]; f++)
        runFrame(tL[r], tW[r], tPre[r], tPost[r], 1'b0, "");

    // R4: line strobe with leading strobe counts as line 1; length 10 predicted next
    runFrame(10, 2, 0, 0, 1'b1, "R4");
    runFrame(10, 2, 3, 0, 1'b0, "R4");

    // R7: line strobe on the trailing strobe is not counted
    preLines = 0; postLines = 2;
    cyc(0, 1, 0);
    cyc(1, 0, 0);
    cyc(1, 0, 1);
    check(coast, 1'b1, "R7", "coincident trail and line");
    cyc(1, 0, 0);
    check(coast, 1'b1, "R7", "first counted line after trail");
    cyc(1, 0, 0);
    check(coast, 1'b0, "R7", "second counted line after trail");

    done = 1;
    summary();
    $finish;
  end
endmodule